// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the device side of a parallel ATA disk register interface. The host reaches eight byte-wide task-file locations through a three-bit address with read and write strobes. The block keeps the parameter registers and decodes the command byte. It runs five commands: IDENTIFY, FLUSH CACHE, READ DMA, WRITE DMA and PACKET. Its status byte and interrupt line track each command's phases cycle by cycle.

Data movement is left to the neighbours. DMA commands become a request/done handshake that carries the direction, a 24-bit sector address and a sector count. A flush becomes a request to the media back end that waits for its done pulse. IDENTIFY data comes out as 16-bit PIO words from a small computed ROM. The words of a PACKET command go out one per data-register write, and the command then enters the DMA handshake with a packet flag set.

An interrupt is raised at each completion and at the start of IDENTIFY. A host read of the status location clears it.

Top module: `ata_tf_ctrl`

## Requirements
- R1: After reset the status reads 0x40, and irq, dma_req and flush_req are low. In the status byte, bit 7 is busy (0x80), bit 6 is ready (0x40), bit 3 is data request (0x08) and bit 0 is error (0x01). Bit 5 always reads 0.
- R2: Writes to addresses 1 to 6 (feature, count, sector bits 7:0, sector bits 15:8, sector bits 23:16, device) are stored and read back in the low byte, with the high byte 0. A read of address 7 returns the status.
- R3: Writing opcode 0xEC to address 7 raises irq and sets the status to 0x48. The status stays 0x48 through the first 255 reads of address 0. The 256th read returns the status to 0x40.
- R4: The IDENTIFY words are: word 0 = 0x0040, word 49 = 0x0300, word 60 = capacity bits 15:0, word 61 = capacity bits 31:16, words 82 and 85 = 0x0020 (bit 5 reports the write cache as supported and enabled), every other word 0.
- R5: Opcode 0xE7 sets the status to 0xC0 and holds flush_req high until flush_done. The cycle after flush_done, the status is 0x40 and irq is high.
- R6: Opcode 0xC8 (dma_to_host=1) or 0xCA (dma_to_host=0) holds dma_req high with status 0xC0. dma_lba is {addr 5, addr 4, addr 3} and dma_count is the count register. On dma_done the status becomes 0x40, or 0x41 if dma_err is high, and irq rises.
- R7: Opcode 0xA0 sets the status to 0x48. Each write to address 0 is passed out on pkt_wvalid/pkt_wdata. After the sixth write the block enters the DMA phase with dma_packet=1 and dma_to_host=1.
- R8: Any other opcode sets the status to 0x41 and raises irq.
- R9: A read of address 7 clears irq on the next cycle. If a completion falls in the same cycle as that read, the read returns the old status and irq stays set.
- R10: A command write is ignored while a command is in progress, or while device bit 4 is 1 (the second drive, which is absent). Writes to addresses 1 to 6 are ignored while the busy bit is set.
- R11: Acceptance of any command clears a previous error bit.
- R12: The busy and data request bits are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Task-file location |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 16 | Host write data (low byte for registers) |
| host_rdata | output | 16 | Read data for the addressed location |
| irq | output | 1 | Interrupt request to the host |
| dma_req | output | 1 | DMA phase active |
| dma_to_host | output | 1 | 1 = device to host |
| dma_packet | output | 1 | DMA belongs to a PACKET command |
| dma_lba | output | 24 | Starting sector address |
| dma_count | output | 8 | Sector count |
| dma_done | input | 1 | DMA finished pulse |
| dma_err | input | 1 | DMA finished with error, valid with dma_done |
| flush_req | output | 1 | Flush request to media |
| flush_done | input | 1 | Flush finished pulse |
| pkt_wvalid | output | 1 | A packet word is being written |
| pkt_wdata | output | 16 | Packet word |

## Verification
A status read and a completion event can fall in the same cycle. When that happens, the clear from the read competes with the set from the completion. The bench provokes this by asserting a status read together with flush_done. It then expects the read to return the busy status 0xC0, and expects irq to stay high afterwards so that the completion is not lost. A following status read must then show 0x40 and drop irq.

// File: rtl/ata_pkg.sv
package ata_pkg;
    localparam logic [7:0] SB_BUSY  = 8'h80;
    localparam logic [7:0] SB_READY = 8'h40;
    localparam logic [7:0] SB_DREQ  = 8'h08;
    localparam logic [7:0] SB_ERR   = 8'h01;

    localparam logic [7:0] OP_RD_DMA = 8'hC8;
    localparam logic [7:0] OP_WR_DMA = 8'hCA;
    localparam logic [7:0] OP_FLUSH  = 8'hE7;
    localparam logic [7:0] OP_IDENT  = 8'hEC;
    localparam logic [7:0] OP_PACKET = 8'hA0;

    localparam logic [2:0] A_DATA    = 3'd0;
    localparam logic [2:0] A_FEAT    = 3'd1;
    localparam logic [2:0] A_COUNT   = 3'd2;
    localparam logic [2:0] A_LBA0    = 3'd3;
    localparam logic [2:0] A_LBA1    = 3'd4;
    localparam logic [2:0] A_LBA2    = 3'd5;
    localparam logic [2:0] A_DEV     = 3'd6;
    localparam logic [2:0] A_CMDSTAT = 3'd7;

    localparam int DEV_SEL_BIT = 4;
    localparam int NUM_TF_REGS = 6;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_IDENT = 3'd1,
        PH_FLUSH = 3'd2,
        PH_DMA   = 3'd3,
        PH_PKT   = 3'd4
    } phase_t;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       lock,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] feat,
    output logic [7:0] count,
    output logic [7:0] lba0,
    output logic [7:0] lba1,
    output logic [7:0] lba2,
    output logic [7:0] dev
);
    logic [NUM_TF_REGS-1:0][7:0] file_d, file_q;

    always_comb begin
        file_d = file_q;
        if (wr_en && !lock) begin
            for (int i = 0; i < NUM_TF_REGS; i++) begin
                if (addr == 3'(i + 1)) file_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) file_q <= '0;
        else        file_q <= file_d;
    end

    assign feat  = file_q[A_FEAT  - 1];
    assign count = file_q[A_COUNT - 1];
    assign lba0  = file_q[A_LBA0  - 1];
    assign lba1  = file_q[A_LBA1  - 1];
    assign lba2  = file_q[A_LBA2  - 1];
    assign dev   = file_q[A_DEV   - 1];

    // R10
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock) |=> $stable(file_q));
endmodule

// File: rtl/ata_id_rom.sv
module ata_id_rom #(
    parameter int          IDX_W    = 8,
    parameter logic [31:0] CAPACITY = 32'h0002_0000
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);
    always_comb begin
        word = 16'h0000;
        case (idx)
            IDX_W'(0):  word = 16'h0040;
            IDX_W'(49): word = 16'h0300;
            IDX_W'(60): word = CAPACITY[15:0];
            IDX_W'(61): word = CAPACITY[31:16];
            IDX_W'(82): word = 16'h0020;
            IDX_W'(85): word = 16'h0020;
            default:    word = 16'h0000;
        endcase
    end
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
    import ata_pkg::*;
#(
    parameter int          ID_WORDS  = 256,
    parameter int          PKT_WORDS = 6,
    parameter logic [31:0] CAPACITY  = 32'h0002_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        irq,
    output logic        dma_req,
    output logic        dma_to_host,
    output logic        dma_packet,
    output logic [23:0] dma_lba,
    output logic [7:0]  dma_count,
    input  logic        dma_done,
    input  logic        dma_err,
    output logic        flush_req,
    input  logic        flush_done,
    output logic        pkt_wvalid,
    output logic [15:0] pkt_wdata
);
    localparam int CNT_MAX = (ID_WORDS > PKT_WORDS) ? ID_WORDS : PKT_WORDS;
    localparam int IDX_W   = $clog2(CNT_MAX);
    localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_WORDS - 1);
    localparam logic [IDX_W-1:0] PKT_LAST = IDX_W'(PKT_WORDS - 1);

    typedef struct packed {
        phase_t           ph;
        logic             err;
        logic             irq;
        logic             to_host;
        logic             pkt;
        logic [IDX_W-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [7:0]  status;
    logic        busy, irq_set;
    logic [7:0]  r_feat, r_count, r_lba0, r_lba1, r_lba2, r_dev;
    logic [15:0] id_word;

    wire stat_rd = host_rd && (host_addr == A_CMDSTAT);
    wire cmd_wr  = host_wr && (host_addr == A_CMDSTAT);
    wire data_rd = host_rd && (host_addr == A_DATA);
    wire data_wr = host_wr && (host_addr == A_DATA);

    always_comb begin
        case (ctl_q.ph)
            PH_IDLE:           status = SB_READY | (ctl_q.err ? SB_ERR : 8'h00);
            PH_IDENT, PH_PKT:  status = SB_READY | SB_DREQ;
            default:           status = SB_BUSY | SB_READY;
        endcase
    end
    assign busy = status[7];

    ata_tf_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .lock(busy),
        .addr(host_addr), .wdata(host_wdata[7:0]),
        .feat(r_feat), .count(r_count), .lba0(r_lba0),
        .lba1(r_lba1), .lba2(r_lba2), .dev(r_dev)
    );

    ata_id_rom #(.IDX_W(IDX_W), .CAPACITY(CAPACITY)) u_rom (
        .idx(ctl_q.idx), .word(id_word)
    );

    always_comb begin
        case (host_addr)
            A_DATA:  host_rdata = (ctl_q.ph == PH_IDENT) ? id_word : 16'h0000;
            A_FEAT:  host_rdata = {8'h00, r_feat};
            A_COUNT: host_rdata = {8'h00, r_count};
            A_LBA0:  host_rdata = {8'h00, r_lba0};
            A_LBA1:  host_rdata = {8'h00, r_lba1};
            A_LBA2:  host_rdata = {8'h00, r_lba2};
            A_DEV:   host_rdata = {8'h00, r_dev};
            default: host_rdata = {8'h00, status};
        endcase
    end

    always_comb begin
        ctl_d   = ctl_q;
        irq_set = 1'b0;
        if (stat_rd) ctl_d.irq = 1'b0;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (cmd_wr && !r_dev[DEV_SEL_BIT]) begin
                    ctl_d.err = 1'b0;
                    ctl_d.idx = '0;
                    ctl_d.pkt = 1'b0;
                    case (host_wdata[7:0])
                        OP_IDENT:  begin ctl_d.ph = PH_IDENT; irq_set = 1'b1; end
                        OP_FLUSH:  ctl_d.ph = PH_FLUSH;
                        OP_RD_DMA: begin ctl_d.ph = PH_DMA; ctl_d.to_host = 1'b1; end
                        OP_WR_DMA: begin ctl_d.ph = PH_DMA; ctl_d.to_host = 1'b0; end
                        OP_PACKET: ctl_d.ph = PH_PKT;
                        default:   begin ctl_d.err = 1'b1; irq_set = 1'b1; end
                    endcase
                end
            end
            PH_IDENT: begin
                if (data_rd) begin
                    if (ctl_q.idx == ID_LAST) ctl_d.ph = PH_IDLE;
                    else                      ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            PH_FLUSH: begin
                if (flush_done) begin
                    ctl_d.ph = PH_IDLE;
                    irq_set  = 1'b1;
                end
            end
            PH_DMA: begin
                if (dma_done) begin
                    ctl_d.ph  = PH_IDLE;
                    ctl_d.err = dma_err;
                    irq_set   = 1'b1;
                end
            end
            PH_PKT: begin
                if (data_wr) begin
                    if (ctl_q.idx == PKT_LAST) begin
                        ctl_d.ph      = PH_DMA;
                        ctl_d.to_host = 1'b1;
                        ctl_d.pkt     = 1'b1;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
        if (irq_set) ctl_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq         = ctl_q.irq;
    assign dma_req     = (ctl_q.ph == PH_DMA);
    assign dma_to_host = ctl_q.to_host;
    assign dma_packet  = ctl_q.pkt;
    assign dma_lba     = {r_lba2, r_lba1, r_lba0};
    assign dma_count   = r_count;
    assign flush_req   = (ctl_q.ph == PH_FLUSH);
    assign pkt_wvalid  = (ctl_q.ph == PH_PKT) && data_wr;
    assign pkt_wdata   = host_wdata;

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !irq_set) |=> !irq);

    // R3
    ident_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_IDENT && data_rd && ctl_q.idx == ID_LAST) |=> (status == SB_READY));

    // R5
    handoff_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req || flush_req) |-> (status[7] && status[6]));

    // R12
    busy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[7] && status[3]));

    // R10
    cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !dma_done && !flush_done) |=> $stable(ctl_q.ph));

    // R6
    dma_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_done) |=> (irq && !dma_req && status[0] == $past(dma_err)));
endmodule

// File: tb/sim_ata_tf_ctrl.sv
module sim_ata_tf_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq, dma_req, dma_to_host, dma_packet, flush_req, pkt_wvalid;
    logic [23:0] dma_lba;
    logic [7:0]  dma_count;
    logic        dma_done = 1'b0, dma_err = 1'b0, flush_done = 1'b0;
    logic [15:0] pkt_wdata;

    always #5 clk = ~clk;

    ata_tf_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .dma_req(dma_req), .dma_to_host(dma_to_host),
        .dma_packet(dma_packet), .dma_lba(dma_lba), .dma_count(dma_count),
        .dma_done(dma_done), .dma_err(dma_err), .flush_req(flush_req),
        .flush_done(flush_done), .pkt_wvalid(pkt_wvalid), .pkt_wdata(pkt_wdata)
    );

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0, pkt_cnt = 0;
    logic [15:0] pkt_last = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each read against the queued expectation
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (host_rd) begin
                if (exp_q.size() == 0) chk("queue empty", 0, 1);
                else begin
                    e = exp_q.pop_front();
                    chk(e.tag, host_rdata, e.val);
                end
            end
        end
    end

    always @(posedge clk) if (pkt_wvalid) begin
        pkt_cnt  <= pkt_cnt + 1;
        pkt_last <= pkt_wdata;
    end

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back('{e, tag});
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk); host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic dma_finish(input logic with_err);
        @(negedge clk); dma_done = 1'b1; dma_err = with_err;
        @(negedge clk); dma_done = 1'b0; dma_err = 1'b0;
    endtask

    function automatic logic [15:0] id_word(input int i);
        case (i)
            0:       return 16'h0040;
            49:      return 16'h0300;
            60:      return 16'h0000;
            61:      return 16'h0002;
            82, 85:  return 16'h0020;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 flush_req", flush_req, 0);
        rd(3'd7, 16'h0040, "R1 status");

        // R2 register file readback
        wr(3'd1, 16'hAB5A);
        wr(3'd2, 16'h0002);
        wr(3'd3, 16'h0011);
        wr(3'd4, 16'h0022);
        wr(3'd5, 16'h0033);
        wr(3'd6, 16'h0040);
        rd(3'd1, 16'h005A, "R2 feature");
        rd(3'd2, 16'h0002, "R2 count");
        rd(3'd3, 16'h0011, "R2 lba0");
        rd(3'd5, 16'h0033, "R2 lba2");
        rd(3'd6, 16'h0040, "R2 device");

        // R6 READ DMA
        wr(3'd7, 16'h00C8);
        chk("R6 dma_req", dma_req, 1);
        chk("R6 dir", dma_to_host, 1);
        chk("R6 pkt", dma_packet, 0);
        chk("R6 lba", dma_lba, 24'h332211);
        chk("R6 count", dma_count, 8'h02);
        rd(3'd7, 16'h00C0, "R6 busy status");
        // R10 writes and commands ignored while busy
        wr(3'd3, 16'h0099);
        wr(3'd7, 16'h00EC);
        chk("R10 still dma", dma_req, 1);
        rd(3'd3, 16'h0011, "R10 lba0 locked");
        rd(3'd7, 16'h00C0, "R10 status");
        dma_finish(1'b0);
        chk("R6 irq", irq, 1);
        rd(3'd7, 16'h0040, "R6 done status");
        chk("R9 irq cleared", irq, 0);

        // R6 WRITE DMA with error
        wr(3'd7, 16'h00CA);
        chk("R6 write dir", dma_to_host, 0);
        dma_finish(1'b1);
        rd(3'd7, 16'h0041, "R6 error status");

        // R5 / R11 flush, with collision of read and completion (R9)
        wr(3'd7, 16'h00E7);
        chk("R5 flush_req", flush_req, 1);
        rd(3'd7, 16'h00C0, "R11 err cleared, R5 flush status");
        chk("R5 irq low while pending", irq, 0);
        exp_q.push_back('{16'h00C0, "R9 collision read"});
        @(negedge clk); host_addr = 3'd7; host_rd = 1'b1; flush_done = 1'b1;
        @(negedge clk); host_rd = 1'b0; flush_done = 1'b0;
        chk("R9 irq kept on collision", irq, 1);
        chk("R5 flush_req dropped", flush_req, 0);
        rd(3'd7, 16'h0040, "R5 done status");
        chk("R9 irq cleared after", irq, 0);

        // R8 unsupported opcode
        wr(3'd7, 16'h0055);
        chk("R8 irq", irq, 1);
        rd(3'd7, 16'h0041, "R8 status");

        // R10 second drive selected
        wr(3'd6, 16'h0050);
        wr(3'd7, 16'h00E7);
        chk("R10 drive1 flush_req", flush_req, 0);
        rd(3'd7, 16'h0041, "R10 drive1 status");
        wr(3'd6, 16'h0040);

        // R3 / R4 IDENTIFY
        wr(3'd7, 16'h00EC);
        chk("R3 irq", irq, 1);
        rd(3'd7, 16'h0048, "R3 R12 status");
        for (int i = 0; i < 256; i++) begin
            rd(3'd0, id_word(i), "R4 word");
            if (i == 254) rd(3'd7, 16'h0048, "R3 before last");
        end
        rd(3'd7, 16'h0040, "R3 after last");

        // R7 PACKET
        wr(3'd7, 16'h00A0);
        rd(3'd7, 16'h0048, "R7 status");
        for (int i = 0; i < 5; i++) wr(3'd0, 16'h1200 + 16'(i));
        chk("R7 no dma yet", dma_req, 0);
        wr(3'd0, 16'hBEEF);
        chk("R7 dma_req", dma_req, 1);
        chk("R7 packet flag", dma_packet, 1);
        chk("R7 dir", dma_to_host, 1);
        chk("R7 word count", pkt_cnt, 6);
        chk("R7 last word", pkt_last, 16'hBEEF);
        rd(3'd7, 16'h00C0, "R7 busy");
        dma_finish(1'b0);
        chk("R7 irq", irq, 1);
        rd(3'd7, 16'h0040, "R7 done");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule